// File: doc/BRIEF.md
# RTC Update-Cycle Interrupt Controller

This block produces the once-per-second update cycle of a PC-style real-time clock, together with the status and interrupt flags that go with it. A time-base strobe (nominally 32.768 kHz) advances a sub-second counter. Shortly before each one-second boundary the block shows an "update busy" bit. At the boundary it completes the update. Completing the update raises an update-done flag, can request an interrupt, and emits a one-cycle strobe telling a calendar unit elsewhere to advance its seconds.

Software reaches the block through a small register bus. A status register shows the busy bit. A control register holds the update-interrupt enable and a freeze bit that stops update cycles. An event register holds the done flag and the interrupt-request flag, and reading it clears both. The bus is plain control: one access per cycle, no back-pressure, and read data is combinational from the current state while `bus_rd` is high.

Top module: `rtc_update_ctrl`

## Requirements
- R1: Bit 7 of the status register (address 0) reads 1 while the sub-second counter is in its last UIP_TICKS positions and the freeze bit is 0, and reads 0 otherwise. The defaults give 8 ticks of 32768.
- R2: On the time-base tick that wraps the counter from TICKS_PER_SEC-1 to 0 with freeze 0, the done flag (event register bit 4, address 2) is set and the busy bit reads 0 afterwards.
- R3: If the interrupt enable (control register bit 4, address 1) is 1 when an update completes, the request flag (event register bit 7) is set and `irq` goes high in the following cycle. With the enable at 0, `irq` stays low.
- R4: While the freeze bit (control register bit 7) is 1, the busy bit reads 0, no update completes, the done flag is not set and `sec_advance` stays low.
- R5: A read of the event register returns its current value. From the next cycle on the register reads 0x00 and `irq` is low.
- R6: A write to the control register that moves the interrupt enable from 0 to 1 while the done flag is set drives `irq` high in the next cycle and sets the request flag.
- R7: `sec_advance` is high for exactly the one cycle after each completed update.
- R8: An interrupt-raising event that occurs while `irq` is already high drives `irq` low for one cycle and then high again.
- R9: Enabling the interrupt while the counter is already inside the busy window shows the busy bit at once and completes the update, with an interrupt, at the next boundary.
- R10: If an event-register read and an update completion fall in the same cycle, the read returns the old value and the new flags are kept.
- R11: A synchronous active-high reset clears the counter, all registers, `irq` and `sec_advance`.
- R12: The control register reads back its last written byte. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base strobe, one cycle per sub-second tick |
| bus_addr | input | 2 | Register select: 0 status, 1 control, 2 event |
| bus_rd | input | 1 | Read strobe; an event-register read clears it |
| bus_wr | input | 1 | Write strobe; only the control register is writable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Active-high interrupt line |
| sec_advance | output | 1 | One-cycle strobe per completed update |

## Verification
The bench builds the block with a 64-tick second and an 8-tick busy window, with `tick_en` held high. Each second then lasts 64 clock cycles, so many boundaries fit in one run: window edges, wraps while frozen, back-to-back interrupts and reads that collide with a completion. The logic is the same at the default 32768-tick second; only the counter width and the window start change.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_EVENT  = 2'd2,
    SEL_NONE   = 2'd3
  } rtc_sel_e;

  localparam int STAT_BUSY_BIT = 7;
  localparam int CTRL_FRZ_BIT  = 7;
  localparam int CTRL_IEN_BIT  = 4;
  localparam int EVT_REQ_BIT   = 7;
  localparam int EVT_DONE_BIT  = 4;
endpackage

// File: rtl/rtc_subsec_timer.sv
module rtc_subsec_timer #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic freeze,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WIN  = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign busy    = !freeze && (cnt_q >= WIN);
  assign done    = tick_en && at_last && !freeze;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R2: the counter wraps to zero on the last tick
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    tick_en && at_last |=> cnt_q == '0);
  // R1: an update only completes after the busy window was shown
  assert_busy_before_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       busy,
  input  logic       done,
  output logic       freeze,
  output logic       irq,
  output logic       sec_advance
);
  rtc_sel_e   sel;
  logic [7:0] ctrl_q;
  logic       done_q, req_q, line_q, gap_q, sec_q;
  logic       rd_evt, wr_ctrl, ien, ien_rise, raise;

  assign sel      = rtc_sel_e'(bus_addr);
  assign rd_evt   = bus_rd && (sel == SEL_EVENT);
  assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
  assign ien      = ctrl_q[CTRL_IEN_BIT];
  assign freeze   = ctrl_q[CTRL_FRZ_BIT];
  assign ien_rise = wr_ctrl && bus_wdata[CTRL_IEN_BIT] && !ien;
  assign raise    = (done && ien) || (ien_rise && done_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_STATUS: bus_rdata[STAT_BUSY_BIT] = busy;
        SEL_CTRL:   bus_rdata = ctrl_q;
        SEL_EVENT: begin
          bus_rdata[EVT_REQ_BIT]  = req_q;
          bus_rdata[EVT_DONE_BIT] = done_q;
        end
        default:    bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
      line_q <= 1'b0;
      gap_q  <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      sec_q <= done;
      gap_q <= 1'b0;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (rd_evt) begin
        done_q <= 1'b0;
        req_q  <= 1'b0;
        line_q <= 1'b0;
      end
      if (done) done_q <= 1'b1;
      if (raise) begin
        req_q  <= 1'b1;
        line_q <= 1'b1;
        gap_q  <= line_q;
      end
    end
  end

  assign irq         = line_q && !gap_q;
  assign sec_advance = sec_q;

  // R2: completion sets the done flag
  assert_done_flag_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> done_q);
  // R3: enabled completion raises the request flag and the line
  assert_req_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    done && ien |=> req_q && line_q);
  // R5: a read without a new event clears everything
  assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    rd_evt && !done |=> !done_q && !req_q && !irq);
  // R6: enable edge with a pending flag asserts the line
  assert_late_enable_R6: assert property (@(posedge clk) disable iff (rst)
    ien_rise && done_q |=> line_q);
  // R8: a repeat event while high opens a one-cycle gap
  assert_repulse_gap_R8: assert property (@(posedge clk) disable iff (rst)
    done && ien && line_q |=> !irq ##1 irq);
  // R4: no strobe while frozen
  assert_frozen_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    freeze |=> !sec_q);
  // R10: completion beats a colliding read
  assert_read_loses_R10: assert property (@(posedge clk) disable iff (rst)
    rd_evt && done |=> done_q);
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic [1:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sec_advance
);
  logic busy, done, freeze;

  rtc_subsec_timer #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .freeze (freeze),
    .busy   (busy),
    .done   (done)
  );

  rtc_status_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .done       (done),
    .freeze     (freeze),
    .irq        (irq),
    .sec_advance(sec_advance)
  );

  // R11: outputs quiet in the cycle after reset
  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> !irq && !sec_advance);
endmodule

// File: tb/rtc_update_ctrl_test.sv
module rtc_update_ctrl_test;
  localparam int TPS = 64;
  localparam int WIN = 8;
  localparam logic [1:0] K_RUN = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_IRQ = 2'd3;
  // [15:14] kind, [13:12] address, [11:4] position/data/expected, [3:0] requirement
  localparam int NV = 28;
  localparam logic [15:0] TBL [0:NV-1] = '{
    {K_RUN, 2'd0, 8'd55,   4'd1},
    {K_RD,  2'd0, 8'h00,   4'd1},   // R1 just before window
    {K_RUN, 2'd0, 8'd56,   4'd1},
    {K_RD,  2'd0, 8'h80,   4'd1},   // R1 first window tick
    {K_RUN, 2'd0, 8'd63,   4'd1},
    {K_RD,  2'd0, 8'h80,   4'd1},   // R1 last window tick
    {K_RD,  2'd0, 8'h00,   4'd2},   // R2 busy clear after wrap
    {K_RD,  2'd2, 8'h10,   4'd2},   // R2 done flag
    {K_RD,  2'd2, 8'h00,   4'd5},   // R5 cleared by read
    {K_IRQ, 2'd0, 8'd0,    4'd3},
    {K_WR,  2'd1, 8'h10,   4'd3},
    {K_RUN, 2'd0, 8'd0,    4'd3},
    {K_IRQ, 2'd0, 8'd1,    4'd3},   // R3 line high
    {K_RD,  2'd2, 8'h90,   4'd3},   // R3 both flags
    {K_IRQ, 2'd0, 8'd0,    4'd5},   // R5 line dropped
    {K_WR,  2'd1, 8'h90,   4'd4},
    {K_RUN, 2'd0, 8'd60,   4'd4},
    {K_RD,  2'd0, 8'h00,   4'd4},   // R4 no busy when frozen
    {K_RUN, 2'd0, 8'd0,    4'd4},
    {K_RD,  2'd2, 8'h00,   4'd4},   // R4 no done when frozen
    {K_RD,  2'd1, 8'h90,   4'd12},  // R12 control readback
    {K_WR,  2'd1, 8'h00,   4'd3},
    {K_RUN, 2'd0, 8'd0,    4'd3},
    {K_IRQ, 2'd0, 8'd0,    4'd3},   // R3 disabled: no line
    {K_WR,  2'd1, 8'h10,   4'd6},
    {K_IRQ, 2'd0, 8'd1,    4'd6},   // R6 late enable
    {K_RD,  2'd2, 8'h90,   4'd6},   // R6 request flag set
    {K_RD,  2'd3, 8'h00,   4'd12}   // R12 unused address
  };

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, sec_advance;
  int pos = 0, errors = 0, checks = 0;

  always #5 clk = ~clk;

  rtc_update_ctrl #(.TICKS_PER_SEC(TPS), .UIP_TICKS(WIN)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sec_advance(sec_advance));

  task automatic cyc();
    @(negedge clk);
    if (tick_en) pos = (pos + 1) % TPS;
  endtask

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d at pos %0d: got %02h expected %02h", req, pos, got, exp);
    end
  endtask

  task automatic run_to(input int p);
    do cyc(); while (pos != p);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int req);
    logic [7:0] got;
    bus_addr = a; bus_rd = 1'b1;
    #1 got = bus_rdata;
    check(req, got, exp);
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(11, {7'd0, irq}, 8'h00);
    check(11, {7'd0, sec_advance}, 8'h00);
    rd(2'd0, 8'h00, 11);
    rd(2'd2, 8'h00, 11);
    rd(2'd1, 8'h00, 11);
    tick_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic [1:0] a;
      logic [7:0] d;
      int rq;
      k = TBL[i][15:14]; a = TBL[i][13:12]; d = TBL[i][11:4]; rq = int'(TBL[i][3:0]);
      case (k)
        K_RUN: run_to(int'(d));
        K_RD:  rd(a, d, rq);
        K_WR:  wr(a, d);
        default: check(rq, {7'd0, irq}, d);
      endcase
    end

    // R7 strobe timing
    wr(2'd1, 8'h00);
    run_to(63);
    check(7, {7'd0, sec_advance}, 8'h00);
    cyc();
    check(7, {7'd0, sec_advance}, 8'h01);
    cyc();
    check(7, {7'd0, sec_advance}, 8'h00);
    rd(2'd2, 8'h10, 7);
    // R4 strobe suppressed while frozen
    wr(2'd1, 8'h80);
    run_to(0);
    check(4, {7'd0, sec_advance}, 8'h00);

    // R8 repeated event while the line is high
    wr(2'd1, 8'h10);
    run_to(0);
    check(8, {7'd0, irq}, 8'h01);
    run_to(0);
    check(8, {7'd0, irq}, 8'h00);
    cyc();
    check(8, {7'd0, irq}, 8'h01);
    rd(2'd2, 8'h90, 8);

    // R9 enable inside the busy window
    wr(2'd1, 8'h00);
    run_to(58);
    wr(2'd1, 8'h10);
    rd(2'd0, 8'h80, 9);
    run_to(0);
    check(9, {7'd0, irq}, 8'h01);
    rd(2'd2, 8'h90, 9);

    // R10 read colliding with completion
    run_to(63);
    rd(2'd2, 8'h00, 10);
    rd(2'd2, 8'h90, 10);

    finish_run();
  end
endmodule